// File: doc/BRIEF.md
# Character-Synchronous Receiver with Sync Hunt

This block is the receive side of a character-oriented synchronous serial link. Serial bits arrive one per `bit_en` strobe, least significant bit first. While unsynchronized, the receiver slides a window over the incoming stream and compares it, bit by bit, with a programmable sync pattern whose length is set apart from the data character length. Once the pattern is seen, character framing starts at the very next bit. From then on the receiver assembles characters of a programmable width, optionally followed by a parity bit, and emits each one as a single-cycle write toward a receive FIFO. The write carries the data, the received parity bit and a parity-error flag.

Sync characters that show up in the synchronized stream are normally dropped. They can be kept as ordinary data when `load_syn` is set. Several events end reception. Clearing the enable, or losing carrier while carrier auto-start is on, parks the receiver until it is enabled again. A hunt or receiver-reset command sends it straight back to hunting. A matched termination character halts it until a new hunt command arrives. FIFO storage, DMA and checksum verification are outside this block.

Top module: `bisync_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `synced`, `fifo_wvalid` and `term_hit` are 0. When reset ends with the receiver active, it starts hunting with an empty window.
- R2: While hunting, the receiver compares the last `syn_len` bits received with `syn_pattern`, where `syn_pattern[0]` is the earliest bit. The window slides by one bit per strobe. `synced` rises on the cycle after the strobe that completes a match. No write happens while unsynchronized.
- R3: Once synchronized, each character is `char_len` data bits, LSB first, followed by one parity bit when `par_en` is 1. `fifo_wvalid` pulses for one cycle on the cycle after the strobe of a character's last bit. `fifo_wdata[7:0]` holds the data zero-extended, `fifo_wdata[8]` holds the received parity bit (0 when `par_en` is 0), and `fifo_wdata[9]` holds the parity-error flag.
- R4: The parity-error flag is 1 when `par_en` is 1 and the count of ones in the data plus the parity bit is odd (`par_odd`=0) or even (`par_odd`=1). It is always 0 when `par_en` is 0.
- R5: When `load_syn` is 0, a synchronized frame of `char_len`+`par_en` bits is not written if that length equals `syn_len` and its bits equal `syn_pattern`.
- R6: When `load_syn` is 1, such a sync frame is written like data. The sync pattern that achieved synchronization is never written.
- R7: The receiver is inactive when `rx_enable` is 0, or when `cd_autostart` is 1 and `carrier_det` is 0. While inactive, `synced` is 0 and bits are ignored. When it becomes active again, it hunts from an empty window.
- R8: A `hunt_cmd` pulse, or an `rx_reset_cmd` pulse when not halted, returns the receiver to hunting with an empty window. Any partly assembled character is discarded, and so is a character that would complete on that same cycle.
- R9: When `term_en` is 1 and a written character's data equals `term_char`, that character is written, `term_hit` pulses in the same cycle, and the receiver halts with `synced` at 0. In the halted state it ignores bits and `rx_reset_cmd`, and only `hunt_cmd` restarts hunting.
- R10: The sync length (1 to 16 bits) is independent of the data length (1 to 8 bits). For example, a 16-bit sync pattern can frame 7-bit characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a valid serial bit |
| rx_bit | input | 1 | Serial data bit, sampled with `bit_en` |
| rx_enable | input | 1 | Receiver enable |
| carrier_det | input | 1 | Carrier present |
| cd_autostart | input | 1 | Gate reception with `carrier_det` |
| hunt_cmd | input | 1 | Pulse: restart sync hunt |
| rx_reset_cmd | input | 1 | Pulse: receiver reset to hunt (ignored when halted) |
| syn_pattern | input | 16 | Sync pattern, bit 0 received first |
| syn_len | input | 5 | Sync length in bits, 1 to 16 |
| char_len | input | 4 | Data bits per character, 1 to 8 |
| par_en | input | 1 | Parity bit follows each character |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| load_syn | input | 1 | Keep in-stream sync frames as data |
| term_en | input | 1 | Enable termination character |
| term_char | input | 8 | Termination character value |
| fifo_wdata | output | 10 | {parity error, parity bit, data} |
| fifo_wvalid | output | 1 | One-cycle write strobe |
| synced | output | 1 | Receiver is synchronized |
| term_hit | output | 1 | One-cycle pulse on termination match |

## Verification
The hardest situations to reach are the ones where a stop event lands in the middle of a character or on a state that ignores it. Examples are a hunt command four bits into a character, a receiver reset while halted, and bits that keep arriving while the enable is low. The stimulus places these pulses between bit strobes inside an otherwise normal stream. It then sends a fresh sync pattern and data, and checks the write count through the ports. A behavioural model that keeps the bits in queues predicts every output on every clock, so a stray write, a bad alignment or a wrong parity flag shows up on the exact cycle it happens.

// File: rtl/bisync_rx_pkg.sv
package bisync_rx_pkg;

    parameter int unsigned CHAR_MAX  = 8;
    parameter int unsigned SYN_MAX   = 16;
    localparam int unsigned FRAME_MAX = CHAR_MAX + 1;
    localparam int unsigned SLW       = $clog2(SYN_MAX + 1);
    localparam int unsigned CLW       = $clog2(CHAR_MAX + 1);
    localparam int unsigned FLW       = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_HUNT = 2'd1,
        RX_SYNC = 2'd2,
        RX_HALT = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic                perr;
        logic                pbit;
        logic [CHAR_MAX-1:0] data;
    } rx_char_t;

    function automatic logic parity_bad(input logic [CHAR_MAX-1:0] d,
                                        input logic pb, input logic odd);
        return ((^d) ^ pb) != odd;
    endfunction

endpackage

// File: rtl/bsr_hunter.sv
module bsr_hunter #(
    parameter int unsigned WIN = 16,
    localparam int unsigned LW = $clog2(WIN + 1),
    localparam int unsigned IW = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           shift,
    input  logic           din,
    input  logic [WIN-1:0] pattern,
    input  logic [LW-1:0]  pat_len,
    output logic           hit
);
    logic [WIN-1:0] hist;
    logic [WIN-1:0] hist_n;
    logic [LW-1:0]  fill;
    logic           same;
    logic           enough;

    assign hist_n = {hist[WIN-2:0], din};
    assign enough = ({1'b0, fill} + 1'b1) >= {1'b0, pat_len};

    always_comb begin
        same = 1'b1;
        for (int i = 0; i < int'(WIN); i++) begin
            int j;
            j = int'(pat_len) - 1 - i;
            if (j >= 0) begin
                if (hist_n[j[IW-1:0]] != pattern[i]) same = 1'b0;
            end
        end
    end

    assign hit = shift & enough & same & (pat_len != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
            fill <= '0;
        end else if (shift) begin
            hist <= hist_n;
            if (fill != LW'(WIN)) fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/bsr_framer.sv
module bsr_framer #(
    parameter int unsigned FW = 9,
    localparam int unsigned CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift,
    input  logic          din,
    input  logic [CW-1:0] frame_len,
    output logic          done,
    output logic [FW-1:0] frame_n
);
    logic [CW-1:0] cnt;
    logic [FW-1:0] frame;

    always_comb begin
        frame_n = frame;
        for (int i = 0; i < int'(FW); i++) begin
            if (shift && CW'(i) == cnt) frame_n[i] = din;
        end
    end

    assign done = shift && (cnt == frame_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            frame <= '0;
        end else if (shift) begin
            if (done) begin
                cnt   <= '0;
                frame <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
                frame <= frame_n;
            end
        end
    end
endmodule

// File: rtl/bsr_classify.sv
module bsr_classify
    import bisync_rx_pkg::*;
(
    input  logic [FRAME_MAX-1:0] frame,
    input  logic [FLW-1:0]       frame_len,
    input  logic [CLW-1:0]       char_len,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic [SYN_MAX-1:0]   syn_pattern,
    input  logic [SLW-1:0]       syn_len,
    input  logic [CHAR_MAX-1:0]  term_char,
    output rx_char_t             ch,
    output logic                 is_syn,
    output logic                 is_term
);
    localparam int unsigned CMP_W = (FRAME_MAX < SYN_MAX) ? FRAME_MAX : SYN_MAX;

    logic [CHAR_MAX-1:0] d;
    logic                pb;
    logic                bits_eq;

    always_comb begin
        d  = '0;
        pb = 1'b0;
        for (int i = 0; i < int'(CHAR_MAX); i++) begin
            if (i < int'(char_len)) d[i] = frame[i];
        end
        for (int i = 0; i < int'(FRAME_MAX); i++) begin
            if (par_en && i == int'(char_len)) pb = frame[i];
        end
    end

    always_comb begin
        bits_eq = 1'b1;
        for (int i = 0; i < int'(CMP_W); i++) begin
            if (i < int'(frame_len) && frame[i] != syn_pattern[i]) bits_eq = 1'b0;
        end
    end

    assign is_syn  = bits_eq && (int'(frame_len) == int'(syn_len));
    assign is_term = (d == term_char);
    assign ch.data = d;
    assign ch.pbit = pb;
    assign ch.perr = par_en & parity_bad(d, pb, par_odd);
endmodule

// File: rtl/bisync_rx.sv
module bisync_rx
    import bisync_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic                  rx_bit,
    input  logic                  rx_enable,
    input  logic                  carrier_det,
    input  logic                  cd_autostart,
    input  logic                  hunt_cmd,
    input  logic                  rx_reset_cmd,
    input  logic [SYN_MAX-1:0]    syn_pattern,
    input  logic [SLW-1:0]        syn_len,
    input  logic [CLW-1:0]        char_len,
    input  logic                  par_en,
    input  logic                  par_odd,
    input  logic                  load_syn,
    input  logic                  term_en,
    input  logic [CHAR_MAX-1:0]   term_char,
    output logic [CHAR_MAX+1:0]   fifo_wdata,
    output logic                  fifo_wvalid,
    output logic                  synced,
    output logic                  term_hit
);
    rx_state_e            state, state_n;
    logic                 active, stop_now;
    logic                 hunt_hit;
    logic                 fr_done;
    logic [FRAME_MAX-1:0] fr_bits;
    logic [FLW-1:0]       frame_len;
    rx_char_t             ch;
    logic                 c_syn, c_term;
    logic                 accept, to_halt;

    assign active    = rx_enable & ~(cd_autostart & ~carrier_det);
    assign stop_now  = ~active | hunt_cmd | (rx_reset_cmd & (state != RX_HALT));
    assign frame_len = FLW'(char_len) + FLW'(par_en);

    bsr_hunter #(.WIN(SYN_MAX)) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .clr     ((state != RX_HUNT) | stop_now),
        .shift   (bit_en & (state == RX_HUNT)),
        .din     (rx_bit),
        .pattern (syn_pattern),
        .pat_len (syn_len),
        .hit     (hunt_hit)
    );

    bsr_framer #(.FW(FRAME_MAX)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .clr       (state != RX_SYNC),
        .shift     (bit_en & (state == RX_SYNC)),
        .din       (rx_bit),
        .frame_len (frame_len),
        .done      (fr_done),
        .frame_n   (fr_bits)
    );

    bsr_classify u_cls (
        .frame       (fr_bits),
        .frame_len   (frame_len),
        .char_len    (char_len),
        .par_en      (par_en),
        .par_odd     (par_odd),
        .syn_pattern (syn_pattern),
        .syn_len     (syn_len),
        .term_char   (term_char),
        .ch          (ch),
        .is_syn      (c_syn),
        .is_term     (c_term)
    );

    assign accept  = (state == RX_SYNC) & fr_done & (~c_syn | load_syn) & ~stop_now;
    assign to_halt = accept & term_en & c_term;

    always_comb begin
        state_n = state;
        if (!active)                                    state_n = RX_OFF;
        else if (state == RX_OFF)                       state_n = RX_HUNT;
        else if (hunt_cmd)                              state_n = RX_HUNT;
        else if (rx_reset_cmd && state != RX_HALT)      state_n = RX_HUNT;
        else if (state == RX_HUNT && hunt_hit)          state_n = RX_SYNC;
        else if (to_halt)                               state_n = RX_HALT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_OFF;
            fifo_wvalid <= 1'b0;
            fifo_wdata  <= '0;
            term_hit    <= 1'b0;
        end else begin
            state       <= state_n;
            fifo_wvalid <= accept;
            term_hit    <= to_halt;
            if (accept) fifo_wdata <= ch;
        end
    end

    assign synced = (state == RX_SYNC);
endmodule

// File: rtl/bsr_checks.sv
module bsr_checks
    import bisync_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                rx_enable,
    input logic                hunt_cmd,
    input logic                par_en,
    input logic [CHAR_MAX+1:0] fifo_wdata,
    input logic                fifo_wvalid,
    input logic                synced,
    input logic                term_hit
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!synced && !fifo_wvalid && !term_hit));

    a_r2_write_needs_sync: assert property (@(posedge clk) disable iff (rst)
        fifo_wvalid |-> $past(synced));

    a_r4_no_parity_fields: assert property (@(posedge clk) disable iff (rst)
        (fifo_wvalid && !$past(par_en)) |-> (fifo_wdata[CHAR_MAX+1:CHAR_MAX] == 2'b00));

    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> (!synced && !fifo_wvalid));

    a_r8_hunt_drops: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd |=> (!synced && !fifo_wvalid));

    a_r9_term_halts: assert property (@(posedge clk) disable iff (rst)
        term_hit |-> (fifo_wvalid && !synced));
endmodule

bind bisync_rx bsr_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_enable   (rx_enable),
    .hunt_cmd    (hunt_cmd),
    .par_en      (par_en),
    .fifo_wdata  (fifo_wdata),
    .fifo_wvalid (fifo_wvalid),
    .synced      (synced),
    .term_hit    (term_hit)
);

// File: tb/bisync_rx_test.sv
module bisync_rx_test;
    import bisync_rx_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bit_en = 1'b0, rx_bit = 1'b0;
    logic                rx_enable = 1'b1, carrier_det = 1'b1, cd_autostart = 1'b0;
    logic                hunt_cmd = 1'b0, rx_reset_cmd = 1'b0;
    logic [SYN_MAX-1:0]  syn_pattern = 16'h0016;
    logic [SLW-1:0]      syn_len = 5'd8;
    logic [CLW-1:0]      char_len = 4'd8;
    logic                par_en = 1'b0, par_odd = 1'b0, load_syn = 1'b0;
    logic                term_en = 1'b0;
    logic [CHAR_MAX-1:0] term_char = 8'h03;
    logic [CHAR_MAX+1:0] fifo_wdata;
    logic                fifo_wvalid, synced, term_hit;

    int checks = 0, fails = 0, cycles = 0;
    int wcount = 0, tcount = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    bisync_rx uut (.*);

    // behavioural reference model
    int         mstate = 0; // 0 off, 1 hunt, 2 sync, 3 halt
    bit         hq[$];
    bit         fq[$];
    logic       exp_valid = 0, exp_term = 0;
    logic [9:0] exp_data = '0;

    always @(posedge clk) begin
        bit act, stop, go_sync, go_halt;
        cycles++;
        if (rst) begin
            mstate = 0; hq.delete(); fq.delete();
            exp_valid = 0; exp_term = 0; exp_data = '0;
        end else begin
            act  = rx_enable && !(cd_autostart && !carrier_det);
            stop = !act || hunt_cmd || (rx_reset_cmd && mstate != 3);
            go_sync = 0; go_halt = 0;
            exp_valid = 0; exp_term = 0;
            if (mstate == 2 && bit_en) begin
                fq.push_back(rx_bit);
                if (fq.size() == int'(char_len) + int'(par_en)) begin
                    bit is_s, pb;
                    logic [7:0] d;
                    is_s = (fq.size() == int'(syn_len));
                    for (int i = 0; i < fq.size(); i++)
                        if (fq[i] != syn_pattern[i]) is_s = 0;
                    d = '0;
                    for (int i = 0; i < int'(char_len); i++) d[i] = fq[i];
                    pb = par_en ? fq[char_len] : 1'b0;
                    if (!stop && (!is_s || load_syn)) begin
                        exp_valid = 1;
                        exp_data = {par_en && ((($countones(d) + pb) % 2) != par_odd), pb, d};
                        if (term_en && d == term_char) begin exp_term = 1; go_halt = 1; end
                    end
                    fq.delete();
                end
            end
            if (mstate == 1 && bit_en && !stop) begin
                hq.push_back(rx_bit);
                if (hq.size() > int'(syn_len)) void'(hq.pop_front());
                if (hq.size() == int'(syn_len)) begin
                    go_sync = 1;
                    for (int i = 0; i < hq.size(); i++)
                        if (hq[i] != syn_pattern[i]) go_sync = 0;
                end
            end
            if (!act) mstate = 0;
            else if (mstate == 0 || hunt_cmd || (rx_reset_cmd && mstate != 3)) begin
                mstate = 1; hq.delete();
            end else if (go_sync) begin mstate = 2; fq.delete(); hq.delete(); end
            else if (go_halt) mstate = 3;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (fifo_wvalid) wcount++;
        if (term_hit) tcount++;
        checks++;
        if (fifo_wvalid !== exp_valid || synced !== (mstate == 2) || term_hit !== exp_term ||
            (exp_valid && fifo_wdata !== exp_data)) begin
            fails++;
            $display("FAIL %s t=%0t valid=%b/%b synced=%b/%b term=%b/%b data=%h/%h (actual/expected)",
                     cur_req, $time, fifo_wvalid, exp_valid, synced, (mstate == 2),
                     term_hit, exp_term, fifo_wdata, exp_data);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk); hunt_cmd = 1'b1; @(negedge clk); hunt_cmd = 1'b0;
    endtask

    task automatic pulse_rreset();
        @(negedge clk); rx_reset_cmd = 1'b1; @(negedge clk); rx_reset_cmd = 1'b0;
    endtask

    function automatic logic [8:0] with_par(input logic [7:0] d, input logic odd, input logic flip);
        logic p;
        p = (^d) ^ odd ^ flip;
        return {p, d};
    endfunction

    task automatic expect_counts(input string req, input int w, input int t);
        repeat (4) @(negedge clk);
        checks++;
        if (wcount != w || tcount != t) begin
            fails++;
            $display("FAIL %s writes=%0d terms=%0d expected writes=%0d terms=%0d",
                     req, wcount, tcount, w, t);
        end
        wcount = 0; tcount = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (synced !== 1'b0 || fifo_wvalid !== 1'b0 || term_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs synced=%b wvalid=%b term=%b expected 0 0 0",
                     synced, fifo_wvalid, term_hit);
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);
        wcount = 0; tcount = 0;

        // R2 R3 R5: garbage, sync, data, in-stream sync dropped
        cur_req = "R2/R3/R5";
        send_bits(16'h0007, 3);
        send_bits(16'h0016, 8);
        send_bits(16'h0041, 8);
        send_bits(16'h0016, 8);
        send_bits(16'h0042, 8);
        expect_counts("R5", 2, 0);

        // R4 R6: even parity, 9-bit sync kept as data
        cur_req = "R4/R6";
        par_en = 1'b1; par_odd = 1'b0; load_syn = 1'b1;
        syn_len = 5'd9; syn_pattern = {7'd0, with_par(8'h16, 1'b0, 1'b0)};
        pulse_hunt();
        send_bits({7'd0, with_par(8'h16, 1'b0, 1'b0)}, 9);
        send_bits({7'd0, with_par(8'h41, 1'b0, 1'b0)}, 9);
        send_bits({7'd0, with_par(8'h42, 1'b0, 1'b1)}, 9);
        send_bits({7'd0, with_par(8'h16, 1'b0, 1'b0)}, 9);
        expect_counts("R6", 3, 0);
        par_odd = 1'b1;
        syn_pattern = {7'd0, with_par(8'h16, 1'b1, 1'b0)};
        pulse_hunt();
        send_bits({7'd0, with_par(8'h16, 1'b1, 1'b0)}, 9);
        send_bits({7'd0, with_par(8'h5A, 1'b1, 1'b0)}, 9);
        send_bits({7'd0, with_par(8'h5B, 1'b1, 1'b1)}, 9);
        expect_counts("R4", 2, 0);

        // R10: 16-bit sync framing 7-bit characters
        cur_req = "R10";
        par_en = 1'b0; load_syn = 1'b0;
        syn_len = 5'd16; syn_pattern = 16'h3216; char_len = 4'd7;
        pulse_hunt();
        send_bits(16'h3216, 16);
        send_bits(16'h0055, 7);
        send_bits(16'h002A, 7);
        expect_counts("R10", 2, 0);

        // R9: termination character halts; reset ignored; hunt restarts
        cur_req = "R9";
        syn_len = 5'd8; syn_pattern = 16'h0016; char_len = 4'd8; term_en = 1'b1;
        pulse_hunt();
        send_bits(16'h0016, 8);
        send_bits(16'h0041, 8);
        send_bits(16'h0003, 8);
        send_bits(16'h0042, 8);
        expect_counts("R9", 2, 1);
        pulse_rreset();
        send_bits(16'h0016, 8);
        send_bits(16'h0044, 8);
        expect_counts("R9", 0, 0);
        pulse_hunt();
        send_bits(16'h0016, 8);
        send_bits(16'h0045, 8);
        expect_counts("R9", 1, 0);

        // R7: enable dropped mid-character, then carrier loss with auto-start
        cur_req = "R7";
        send_bits(16'h0046, 4);
        @(negedge clk); rx_enable = 1'b0;
        send_bits(16'h0004, 4);
        @(negedge clk); rx_enable = 1'b1;
        send_bits(16'h0047, 8);
        expect_counts("R7", 0, 0);
        send_bits(16'h0016, 8);
        send_bits(16'h0048, 8);
        expect_counts("R7", 1, 0);
        @(negedge clk); cd_autostart = 1'b1; carrier_det = 1'b0;
        send_bits(16'h0016, 8);
        send_bits(16'h0049, 8);
        expect_counts("R7", 0, 0);
        @(negedge clk); carrier_det = 1'b1;
        send_bits(16'h0016, 8);
        send_bits(16'h004A, 8);
        expect_counts("R7", 1, 0);

        // R8: hunt and receiver reset mid-character
        cur_req = "R8";
        send_bits(16'h0046, 4);
        pulse_hunt();
        send_bits(16'h0004, 4);
        send_bits(16'h004B, 8);
        expect_counts("R8", 0, 0);
        send_bits(16'h0016, 8);
        send_bits(16'h004C, 8);
        expect_counts("R8", 1, 0);
        send_bits(16'h0046, 4);
        pulse_rreset();
        send_bits(16'h0016, 8);
        send_bits(16'h004D, 8);
        expect_counts("R8", 1, 0);

        // R1: reset in the middle of synchronized reception
        cur_req = "R1";
        send_bits(16'h0046, 3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        checks++;
        if (synced !== 1'b0 || fifo_wvalid !== 1'b0) begin
            fails++;
            $display("FAIL R1 during reset synced=%b wvalid=%b expected 0 0", synced, fifo_wvalid);
        end
        rst = 1'b0;
        send_bits(16'h0016, 8);
        send_bits(16'h004E, 8);
        expect_counts("R1", 1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule